// File: doc/BRIEF.md
# Windowed Command and Interrupt Controller

This block sits between a host bus and the datapath of a network adapter. The host controls it through a single 16-bit command port. Each word carries a 5-bit opcode in bits 15..11 and an 11-bit argument in bits 10..0. At the same offset the host reads a 16-bit status word. That word shows three things: the selected register window, a busy flag, and eight interrupt source bits.

Datapath events set the source latches. Bit-selective acknowledge commands clear them. Two masks shape what the host sees. The interrupt mask decides which latched sources drive the single interrupt output. The read-zero mask decides which source bits are visible in the status word.

A global reset command returns the internal state to its defaults. It then holds the busy flag for a programmable number of cycles, which stands in for a settling delay of at least a millisecond. While the busy flag is set, incoming commands are refused and a sticky error flag is raised.

Top module: `wcic_top`

## Requirements
- R1: After the `rst` input, the status word reads 0x0000, `window_o` is 0, and `irq_o` and `cmd_err_o` are low. The interrupt mask resets to all zeros and the read-zero mask to all ones.
- R2: Opcode 1 loads the window from argument bits 2..0 and ignores the higher argument bits. The window appears on `window_o` and in status bits 15..13.
- R3: `evt_i[k]` sets status latch k+1, and the latch stays set until it is acknowledged. Status bits 11..8 always read 0. The latch layout from bit 0 up is: interrupt latch, adapter failure, transmit complete, transmit available, receive complete, receive early, interrupt requested, update statistics.
- R4: Opcode 13 clears each status latch whose bit is set in argument bits 7..0, and leaves the other latches unchanged. If an event and an acknowledge hit the same latch in the same cycle, the event wins.
- R5: Opcode 14 loads the interrupt mask from argument bits 7..0. `irq_o` is the OR of status latches 7..1 that the mask enables. A masked source still latches.
- R6: Status bit 0 reads 1 whenever `irq_o` is high, and it stays latched afterwards. Acknowledging bit 0 clears it only while `irq_o` is low.
- R7: Opcode 15 loads the read-zero mask from argument bits 7..0. A status bit 7..0 whose mask bit is 0 reads as 0. The latch underneath and `irq_o` are not affected.
- R8: Opcode 12 sets status latch 6 (interrupt requested).
- R9: Opcode 0 clears all latches and the window, and restores both masks to their reset values. Status bit 12 (busy) then reads 1 for exactly `RST_CYCLES` cycles.
- R10: A command written while busy is ignored and sets `cmd_err_o`. `cmd_err_o` stays set until the `rst` input, and a global reset command does not clear it.
- R11: Opcodes other than 0, 1, 12, 13, 14 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 16 | Command word: opcode 15..11, argument 10..0 |
| evt_i | input | 7 | Datapath event pulses for status latches 7..1 |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt output |
| window_o | output | 3 | Currently selected register window |
| cmd_err_o | output | 1 | Sticky flag for a command written while busy |

## Verification
A command or event presented before a rising edge takes effect at that edge. Its result shows on `status_o`, `irq_o`, `window_o` and `cmd_err_o` after that edge, because the outputs are decoded combinationally from registers, with no further delay. The bench therefore drives each stimulus on a falling edge and samples the following falling edge. The busy window after a global reset is counted sample by sample: it must read 1 in exactly the first `RST_CYCLES` samples and 0 in the next one. A refused write made in the middle of that window is checked on the sample that follows it.

// File: rtl/wcic_pkg.sv
package wcic_pkg;
    localparam int WORD_W = 16;
    localparam int ARG_W  = 11;
    localparam int WIN_W  = 3;
    localparam int SRC_N  = 8;
    localparam int EVT_N  = SRC_N - 1;

    localparam logic [4:0] OP_GRESET = 5'd0;
    localparam logic [4:0] OP_WINSEL = 5'd1;
    localparam logic [4:0] OP_REQINT = 5'd12;
    localparam logic [4:0] OP_ACK    = 5'd13;
    localparam logic [4:0] OP_IMASK  = 5'd14;
    localparam logic [4:0] OP_RZMASK = 5'd15;

    // index of the interrupt-requested latch inside the 7-bit event vector
    localparam int REQINT_IDX = 5;
    localparam int BUSY_BIT   = 12;

    typedef struct packed {
        logic             greset;
        logic             winsel;
        logic             reqint;
        logic             ack;
        logic             imask;
        logic             rzmask;
        logic [ARG_W-1:0] arg;
    } cmd_s;

    function automatic cmd_s decode_cmd(logic [WORD_W-1:0] w, logic take);
        cmd_s c;
        logic [4:0] op;
        op       = w[WORD_W-1 -: 5];
        c.arg    = w[ARG_W-1:0];
        c.greset = take && (op == OP_GRESET);
        c.winsel = take && (op == OP_WINSEL);
        c.reqint = take && (op == OP_REQINT);
        c.ack    = take && (op == OP_ACK);
        c.imask  = take && (op == OP_IMASK);
        c.rzmask = take && (op == OP_RZMASK);
        return c;
    endfunction
endpackage

// File: rtl/wcic_cmd_decode.sv
module wcic_cmd_decode
    import wcic_pkg::*;
(
    input  logic              wr,
    input  logic [WORD_W-1:0] word,
    input  logic              busy,
    output cmd_s              cmd,
    output logic              refused
);
    always_comb begin
        cmd     = decode_cmd(word, wr && !busy);
        refused = wr && busy;
    end
endmodule

// File: rtl/wcic_busy_timer.sv
module wcic_busy_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(RST_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/wcic_src_latch.sv
module wcic_src_latch
    import wcic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_s             cmd,
    input  logic [EVT_N-1:0] evt,
    output logic [SRC_N-1:0] src_view,
    output logic             irq
);
    logic [EVT_N-1:0] lat;
    logic             lat0;
    logic [SRC_N-1:0] imask;
    logic [SRC_N-1:0] rzmask;
    logic [EVT_N-1:0] clr;
    logic [EVT_N-1:0] req;

    always_comb begin
        clr = cmd.ack ? cmd.arg[SRC_N-1:1] : '0;
        req = '0;
        req[REQINT_IDX] = cmd.reqint;
        irq = |(lat & imask[SRC_N-1:1]);
        src_view = {lat, lat0 | irq} & rzmask;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.greset) begin
            lat    <= '0;
            lat0   <= 1'b0;
            imask  <= '0;
            rzmask <= '1;
        end else begin
            lat  <= (lat & ~clr) | evt | req;
            lat0 <= (lat0 | irq) & ~(cmd.ack & cmd.arg[0]);
            if (cmd.imask)
                imask <= cmd.arg[SRC_N-1:0];
            if (cmd.rzmask)
                rzmask <= cmd.arg[SRC_N-1:0];
        end
    end
endmodule

// File: rtl/wcic_top.sv
module wcic_top
    import wcic_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr_i,
    input  logic [WORD_W-1:0] cmd_word_i,
    input  logic [EVT_N-1:0]  evt_i,
    output logic [WORD_W-1:0] status_o,
    output logic              irq_o,
    output logic [WIN_W-1:0]  window_o,
    output logic              cmd_err_o
);
    cmd_s             cmd;
    logic             refused;
    logic             busy;
    logic [SRC_N-1:0] src_view;
    logic [WIN_W-1:0] win_q;
    logic             err_q;

    wcic_cmd_decode u_dec (
        .wr      (cmd_wr_i),
        .word    (cmd_word_i),
        .busy    (busy),
        .cmd     (cmd),
        .refused (refused)
    );

    wcic_busy_timer #(.RST_CYCLES(RST_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.greset),
        .busy  (busy)
    );

    wcic_src_latch u_src (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .evt      (evt_i),
        .src_view (src_view),
        .irq      (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.greset)
            win_q <= '0;
        else if (cmd.winsel)
            win_q <= cmd.arg[WIN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (refused)
            err_q <= 1'b1;
    end

    always_comb begin
        status_o = '0;
        status_o[WORD_W-1 -: WIN_W] = win_q;
        status_o[BUSY_BIT]          = busy;
        status_o[SRC_N-1:0]         = src_view;
    end

    assign window_o  = win_q;
    assign cmd_err_o = err_q;
endmodule

// File: rtl/wcic_checker.sv
module wcic_checker
    import wcic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_wr_i,
    input logic [WORD_W-1:0] cmd_word_i,
    input logic [WORD_W-1:0] status_o,
    input logic              irq_o,
    input logic [WIN_W-1:0]  window_o,
    input logic              cmd_err_o
);
    logic taken;
    assign taken = cmd_wr_i && !status_o[BUSY_BIT];

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        status_o[11:8] == 4'h0);

    p_window_status_r2: assert property (@(posedge clk) disable iff (rst)
        status_o[15:13] == window_o);

    p_winsel_load_r2: assert property (@(posedge clk) disable iff (rst)
        taken && cmd_word_i[15:11] == OP_WINSEL |=> window_o == $past(cmd_word_i[2:0]));

    p_mask_off_r5: assert property (@(posedge clk) disable iff (rst)
        taken && cmd_word_i[15:11] == OP_IMASK && cmd_word_i[7:1] == 7'h0 |=> !irq_o);

    p_greset_busy_r9: assert property (@(posedge clk) disable iff (rst)
        taken && cmd_word_i[15:11] == OP_GRESET |=> status_o[BUSY_BIT] && window_o == '0 && !irq_o);

    p_refuse_err_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_i && status_o[BUSY_BIT] |=> cmd_err_o && $stable(window_o));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_err_o |=> cmd_err_o);
endmodule

bind wcic_top wcic_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_word_i (cmd_word_i),
    .status_o   (status_o),
    .irq_o      (irq_o),
    .window_o   (window_o),
    .cmd_err_o  (cmd_err_o)
);

// File: tb/wcic_top_tb_top.sv
module wcic_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRST = 16;

    typedef struct packed {
        logic        wr;
        logic [15:0] word;
        logic [6:0]  evt;
        logic [15:0] st;
        logic        irq;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h0805, 7'h00, 16'hA000, 1'b0},  // R2 window 5
        '{1'b1, 16'h0FFA, 7'h00, 16'h4000, 1'b0},  // R2 upper arg ignored -> 2
        '{1'b0, 16'h0000, 7'h02, 16'h4004, 1'b0},  // R3 R5 masked source latches
        '{1'b1, 16'h7004, 7'h00, 16'h4005, 1'b1},  // R5 R6 enable bit 2
        '{1'b1, 16'h6804, 7'h00, 16'h4001, 1'b0},  // R4 R6 ack bit 2, bit 0 held
        '{1'b1, 16'h6801, 7'h00, 16'h4000, 1'b0},  // R6 ack bit 0
        '{1'b0, 16'h0000, 7'h08, 16'h4010, 1'b0},  // R3 rx complete
        '{1'b1, 16'h780F, 7'h00, 16'h4000, 1'b0},  // R7 hide bits 7..4
        '{1'b1, 16'h6000, 7'h00, 16'h4000, 1'b0},  // R8 request, hidden
        '{1'b1, 16'h78FF, 7'h00, 16'h4050, 1'b0},  // R7 R8 show all
        '{1'b1, 16'h7040, 7'h00, 16'h4051, 1'b1},  // R5 enable bit 6
        '{1'b1, 16'h68FF, 7'h40, 16'h4080, 1'b0},  // R4 event beats ack
        '{1'b1, 16'h8000, 7'h00, 16'h4080, 1'b0}   // R11 unused opcode
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_wr_i;
    logic [15:0] cmd_word_i;
    logic [6:0]  evt_i;
    logic [15:0] status_o;
    logic        irq_o;
    logic [2:0]  window_o;
    logic        cmd_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcic_top #(.RST_CYCLES(NRST)) dut_i (
        .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr_i), .cmd_word_i(cmd_word_i),
        .evt_i(evt_i), .status_o(status_o), .irq_o(irq_o),
        .window_o(window_o), .cmd_err_o(cmd_err_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on falling edge, sample at the next falling edge
    task automatic step(input logic wr, input logic [15:0] w, input logic [6:0] e);
        cmd_wr_i = wr; cmd_word_i = w; evt_i = e;
        @(negedge clk);
        cmd_wr_i = 1'b0; cmd_word_i = 16'h0; evt_i = 7'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_wr_i = 1'b0; cmd_word_i = 16'h0; evt_i = 7'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 status", status_o, 16'h0000);
        chk("R1 irq/err/win", {11'h0, irq_o, cmd_err_o, window_o}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].wr, VEC[i].word, VEC[i].evt);
            chk($sformatf("vector %0d status (R2..R11)", i), status_o, VEC[i].st);
            chk($sformatf("vector %0d irq (R5)", i), {15'h0, irq_o}, {15'h0, VEC[i].irq});
        end
        chk("R2 window_o", {13'h0, window_o}, 16'h2);

        // R9 global reset and busy window, R10 refused write mid-window
        step(1'b1, 16'h0000, 7'h00);
        for (int i = 1; i <= NRST; i++) begin
            chk($sformatf("R9 busy sample %0d", i), status_o, 16'h1000);
            if (i == 3) step(1'b1, 16'h0803, 7'h00);
            else @(negedge clk);
            if (i == 3) chk("R10 err after refused write", {15'h0, cmd_err_o}, 16'h1);
        end
        chk("R9 busy released", status_o, 16'h0000);
        chk("R10 window unchanged", {13'h0, window_o}, 16'h0);

        // R9 interrupt mask back to zero, read-zero mask back to ones
        step(1'b0, 16'h0, 7'h02);
        chk("R9 masks restored status", status_o, 16'h0004);
        chk("R9 masks restored irq", {15'h0, irq_o}, 16'h0);
        chk("R10 err sticky over global reset", {15'h0, cmd_err_o}, 16'h1);

        // R6 ack of bit 0 while irq high does not hide it
        step(1'b1, 16'h7004, 7'h00);
        step(1'b1, 16'h6801, 7'h00);
        chk("R6 bit0 held by irq", status_o, 16'h0005);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 err cleared by rst", {15'h0, cmd_err_o}, 16'h0);
        chk("R1 status after rst", status_o, 16'h0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule